// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block guesses whether a fetched branch will be taken. It keeps a table of 2-bit hysteresis entries. Each entry is selected by a slice of the fetch address together with a short register of recent branch outcomes. Each entry holds a guessed direction and a flag that marks whether its last guess missed. The direction therefore turns over only after two misses in a row.

The fetch side presents an address every cycle. One clock later it receives a registered guess, along with the history value that selected the entry. The pipeline carries that history with the branch. When the branch resolves, the resolve side returns the branch address, its real outcome and the carried history. The entry that made the guess is then trained, and the outcome is shifted into the history register. Target prediction, the instruction cache and flush control belong to neighbouring blocks.

Top module: `bdp_predictor`

## Requirements
- R1: While `rst_n` is low, every entry returns to guess not-taken with no recorded miss, and the history register and `pred_hist` clear to zero. This holds whatever training happened before the reset.
- R2: An address on `lk_pc` at one rising edge gives `pred_taken` and `pred_hist` after that edge. `pred_hist` is the history value that was in effect at that edge.
- R3: The table index uses address bits [IDX_BITS+1:2]. Address bits [1:0] do not affect the guess.
- R4: For the same address, each history value selects its own entry, so training under one history leaves the guess under another history unchanged.
- R5: An entry with no recorded miss that sees an outcome matching its guess keeps its guess.
- R6: An entry with no recorded miss that sees a mismatching outcome keeps its guessed direction and records one miss.
- R7: An entry with a recorded miss that sees a matching outcome clears the miss, so a later single miss does not flip it.
- R8: An entry with a recorded miss that sees a second mismatching outcome flips its direction and clears the miss.
- R9: Each cycle with `rs_valid` high shifts `rs_taken` into bit 0 of the history and drops the oldest bit. Cycles without `rs_valid` leave the history unchanged.
- R10: A resolve trains the entry chosen by `rs_pc` and `rs_hist`, not the entry chosen by the current history.
- R11: When a lookup and a resolve hit the same entry at the same edge, the lookup returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to look up |
| pred_taken | output | 1 | Registered guess, 1 = taken |
| pred_hist | output | HIST_BITS | History value used for the guess, bit 0 newest |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_hist | input | HIST_BITS | History snapshot returned with the guess |

## Verification
The bench builds the block with PC_W=16, IDX_BITS=3 and HIST_BITS=2. This gives 8 address slots in each of 4 history sets. A history value can be steered with two resolves, so any set can be reached in a few cycles. Every hysteresis transition can then be reached, and the result read back under any chosen history. Aliasing through the low address bits, cross-set isolation and same-edge read/write collisions are all reachable with a handful of hand-picked addresses.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   // bit 1 = guessed direction (1 taken), bit 0 = last guess missed
   typedef enum logic [1:0] {
      ST_NT_OK   = 2'b00,
      ST_NT_MISS = 2'b01,
      ST_T_OK    = 2'b10,
      ST_T_MISS  = 2'b11
   } hyst_e;

   function automatic logic dir_of(hyst_e s);
      return s[1];
   endfunction

   function automatic logic miss_of(hyst_e s);
      return s[0];
   endfunction
endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
   parameter int PC_W      = 32,
   parameter int IDX_BITS  = 10,
   parameter int HIST_BITS = 2,
   localparam int ADDR_W   = IDX_BITS + HIST_BITS
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [HIST_BITS-1:0] hist,
   output logic [ADDR_W-1:0]    idx
);
   generate
      if (PC_W < IDX_BITS + 2) begin : g_bad_pc
         $error("bdp_index: PC_W too narrow for IDX_BITS");
      end
   endgenerate

   // history picks the set, address bits above the byte offset pick the slot
   assign idx = {hist, pc[IDX_BITS+1:2]};
endmodule

// File: rtl/bdp_hyst_next.sv
module bdp_hyst_next
   import bdp_pkg::*;
(
   input  logic  en,
   input  hyst_e cur,
   input  logic  outcome,
   output hyst_e nxt
);
   logic hit;

   always_comb begin
      hit = (dir_of(cur) == outcome);
      if (!miss_of(cur)) begin
         nxt = hit ? cur : hyst_e'({dir_of(cur), 1'b1});
      end else begin
         nxt = hit ? hyst_e'({dir_of(cur), 1'b0})
                   : hyst_e'({~dir_of(cur), 1'b0});
      end
   end

   always_comb begin
      if (en) begin
         // R6: a first miss never changes the guessed direction
         a_r6_first_miss_keeps_dir: assert (miss_of(cur) || dir_of(nxt) == dir_of(cur));
         // R8: second miss in a row flips direction and leaves no miss recorded
         a_r8_second_miss_flips: assert (!(miss_of(cur) && dir_of(cur) != outcome)
                                         || (dir_of(nxt) != dir_of(cur) && !miss_of(nxt)));
         // R7: a correct outcome always leaves the entry with no recorded miss
         a_r7_hit_clears_miss: assert (dir_of(cur) != outcome || !miss_of(nxt));
      end
   end
endmodule

// File: rtl/bdp_table.sv
module bdp_table
   import bdp_pkg::*;
#(
   parameter int ADDR_W = 12,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_idx,
   output hyst_e             rd_q,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   output hyst_e             wr_cur,
   input  hyst_e             wr_data
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_depth
         $error("bdp_table: ADDR_W out of range");
      end
   endgenerate

   hyst_e mem [DEPTH];

   assign wr_cur = mem[wr_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ST_NT_OK;
         rd_q <= ST_NT_OK;
      end else begin
         rd_q <= mem[rd_idx];
         if (wr_en) mem[wr_idx] <= wr_data;
      end
   end
endmodule

// File: rtl/bdp_ghr.sv
module bdp_ghr #(
   parameter int HIST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 bit_in,
   output logic [HIST_BITS-1:0] hist
);
   generate
      if (HIST_BITS < 1) begin : g_bad_hist
         $error("bdp_ghr: HIST_BITS must be at least 1");
      end else if (HIST_BITS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= bit_in;
         end
      end else begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= {hist[HIST_BITS-2:0], bit_in};
         end
      end
   endgenerate

   a_r9_newest_in_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(bit_in));
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));
endmodule

// File: rtl/bdp_predictor.sv
module bdp_predictor
   import bdp_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int IDX_BITS  = 10,
   parameter int HIST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PC_W-1:0]      lk_pc,
   output logic                 pred_taken,
   output logic [HIST_BITS-1:0] pred_hist,
   input  logic                 rs_valid,
   input  logic [PC_W-1:0]      rs_pc,
   input  logic                 rs_taken,
   input  logic [HIST_BITS-1:0] rs_hist
);
   localparam int ADDR_W = IDX_BITS + HIST_BITS;

   logic [HIST_BITS-1:0] ghr;
   logic [ADDR_W-1:0]    lk_idx, rs_idx;
   hyst_e                rd_q, upd_cur, upd_nxt;

   bdp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_lk_idx (
      .pc(lk_pc), .hist(ghr), .idx(lk_idx));

   bdp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_rs_idx (
      .pc(rs_pc), .hist(rs_hist), .idx(rs_idx));

   bdp_table #(.ADDR_W(ADDR_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_q(rd_q),
      .wr_en(rs_valid), .wr_idx(rs_idx), .wr_cur(upd_cur), .wr_data(upd_nxt));

   bdp_hyst_next u_next (
      .en(rs_valid && rst_n), .cur(upd_cur), .outcome(rs_taken), .nxt(upd_nxt));

   bdp_ghr #(.HIST_BITS(HIST_BITS)) u_ghr (
      .clk(clk), .rst_n(rst_n), .shift_en(rs_valid), .bit_in(rs_taken), .hist(ghr));

   always_ff @(posedge clk) begin
      if (!rst_n) pred_hist <= '0;
      else        pred_hist <= ghr;
   end

   assign pred_taken = dir_of(rd_q);

   // R1: the first cycle out of reset reports a not-taken guess under empty history
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!pred_taken && pred_hist == '0));
endmodule

// File: tb/bdp_predictor_test.sv
module bdp_predictor_test;
   localparam int PC_W = 16;
   localparam int IDX = 3;
   localparam int HB = 2;
   localparam int CLK_PERIOD = 10;
   localparam int ENT = 1 << IDX;
   localparam int NSETS = 1 << HB;
   localparam logic [PC_W-1:0] DUMMY_PC = 16'h007C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0;
   logic rs_valid = 1'b0;
   logic [PC_W-1:0] rs_pc = '0;
   logic rs_taken = 1'b0;
   logic [HB-1:0] rs_hist = '0;
   logic pred_taken;
   logic [HB-1:0] pred_hist;

   bit mdir [NSETS*ENT];
   bit mmiss [NSETS*ENT];
   logic [HB-1:0] mghr;
   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   bit exp_t [$];
   logic [HB-1:0] exp_h [$];
   string exp_tag [$];

   bdp_predictor #(.PC_W(PC_W), .IDX_BITS(IDX), .HIST_BITS(HB)) uut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
      .rs_taken(rs_taken), .rs_hist(rs_hist));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int midx(logic [PC_W-1:0] pc, logic [HB-1:0] h);
      return int'(h) * ENT + int'(pc[IDX+1:2]);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NSETS*ENT; i++) begin
         mdir[i] = 1'b0;
         mmiss[i] = 1'b0;
      end
      mghr = '0;
   endtask

   task automatic compare(string tag, bit got_t, logic [HB-1:0] got_h,
                          bit want_t, logic [HB-1:0] want_h);
      compared++;
      if (got_t !== want_t || got_h !== want_h) begin
         mismatched++;
         $display("FAIL %s: got taken=%0d hist=%0d, expected taken=%0d hist=%0d",
                  tag, got_t, got_h, want_t, want_h);
      end
   endtask

   // monitor: one result per pushed lookup, sampled just after the edge
   always @(posedge clk) begin
      #1;
      if (exp_t.size() > 0) begin
         compare(exp_tag.pop_front(), pred_taken, pred_hist,
                 exp_t.pop_front(), exp_h.pop_front());
      end
   end

   // driver: one cycle of stimulus, expected value from the model before update
   task automatic step(logic [PC_W-1:0] pc, bit chk, string tag,
                       bit rv, logic [PC_W-1:0] rpc, bit rt, logic [HB-1:0] rh);
      @(negedge clk);
      lk_pc = pc;
      rs_valid = rv;
      rs_pc = rpc;
      rs_taken = rt;
      rs_hist = rh;
      if (chk) begin
         exp_t.push_back(mdir[midx(pc, mghr)]);
         exp_h.push_back(mghr);
         exp_tag.push_back(tag);
      end
      if (rv) begin
         int i = midx(rpc, rh);
         bit hit = (mdir[i] == rt);
         if (!mmiss[i]) begin
            if (!hit) mmiss[i] = 1'b1;
         end else if (hit) begin
            mmiss[i] = 1'b0;
         end else begin
            mdir[i] = ~mdir[i];
            mmiss[i] = 1'b0;
         end
         mghr = {mghr[HB-2:0], rt};
      end
   endtask

   task automatic look(logic [PC_W-1:0] pc, string tag);
      step(pc, 1'b1, tag, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic res(logic [PC_W-1:0] pc, bit t, logic [HB-1:0] h);
      step('0, 1'b0, "", 1'b1, pc, t, h);
   endtask

   task automatic set_ghr(logic [HB-1:0] h);
      for (int i = HB - 1; i >= 0; i--) res(DUMMY_PC, h[i], 2'd3);
   endtask

   task automatic idle();
      step('0, 1'b0, "", 1'b0, '0, 1'b0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rs_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      @(negedge clk);
      compare("R1 reset outputs", pred_taken, pred_hist, 1'b0, '0);

      look(16'h0040, "R2 first lookup");
      res(16'h0040, 1'b1, 2'd0);              // first miss
      look(16'h0040, "R4 other history set");
      set_ghr(2'd0);
      look(16'h0040, "R6 one miss keeps dir");
      res(16'h0040, 1'b1, 2'd0);              // second miss flips
      set_ghr(2'd0);
      look(16'h0040, "R8 two misses flip");
      look(16'h0042, "R3 low bits ignored");
      look(16'h0044, "R3 next slot separate");

      res(16'h0040, 1'b1, 2'd0);
      set_ghr(2'd0);
      look(16'h0040, "R5 hit keeps guess");

      res(16'h0040, 1'b0, 2'd0);
      res(16'h0040, 1'b1, 2'd0);
      res(16'h0040, 1'b0, 2'd0);
      set_ghr(2'd0);
      look(16'h0040, "R7 hit cleared miss");

      res(16'h0048, 1'b1, 2'd2);
      res(16'h0048, 1'b1, 2'd2);
      look(16'h0048, "R10 current history untouched");
      set_ghr(2'd2);
      look(16'h0048, "R10 snapshot entry trained");

      set_ghr(2'd0);
      res(DUMMY_PC, 1'b1, 2'd3);
      look(16'h0050, "R9 shift one");
      res(DUMMY_PC, 1'b1, 2'd3);
      look(16'h0050, "R9 shift two");
      res(DUMMY_PC, 1'b0, 2'd3);
      look(16'h0050, "R9 oldest dropped");
      look(16'h0050, "R9 hold without resolve");

      set_ghr(2'd0);
      step(16'h0040, 1'b1, "R11 collision pre-update", 1'b1, 16'h0040, 1'b0, 2'd0);
      look(16'h0040, "R11 update visible next");

      do_reset();
      look(16'h0048, "R1 history cleared");
      set_ghr(2'd2);
      look(16'h0048, "R1 trained entry cleared");
      idle();
      idle();
      idle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule